// File: doc/BRIEF.md
# ISA Capability Register Write Legalizer

This block holds the register that advertises which instruction-set extensions a hart currently has turned on. Software writes any value to it. The block keeps only a legal extension set: it either discards a write completely or trims it to a subset the hart can actually support. The rules that decide the result are the dependencies between extensions, the hart's support mask, and the alignment of the next instruction fetch. The base-width field at the top of the register always keeps its stored value.

On every clock edge where a write is accepted, the block compares the trimmed value with the stored one. If they differ, it raises a one-cycle pulse so that downstream logic (decoders, fetch) can react. A global enable input turns the register read-only while it is low.

Extension letters map to bits by position in the alphabet: A is bit 0, C is bit 2, D is bit 3, E is bit 4, F is bit 5, I is bit 8, M is bit 12, S is bit 18, U is bit 20, and Z is bit 25. The base-width field occupies the top two bits of the register. Bits from 26 up to just below that field stay zero.

Top module: `isa_cap_reg`

## Requirements
- R1: After reset the register reads the hart support mask in bits [25:0], 2'b01 in bits [31:30] and zero in bits [29:26], and the change pulse is low.
- R2: While `feat_en_i` is low, a strobed write leaves the register unchanged and raises no pulse.
- R3: A write whose data has bit 8 (I) clear and bit 4 (E) clear is discarded entirely.
- R4: A write whose data has bit 4 (E) set is discarded entirely, whatever the other bits are.
- R5: An accepted write stores its bits [25:0] ANDed with the support mask and with the set {A,C,D,E,F,I,M,S,U} (bits 0,2,3,4,5,8,12,18,20). Every other extension bit reads back zero.
- R6: If, after that masking, bit 3 (D) is set while bit 5 (F) is clear, bit 3 is stored as zero.
- R7: If bit 2 (C) is requested while `fetch_aligned_i` is low (the next fetch address is not 4-byte aligned), bit 2 is stored as zero.
- R8: Bits [31:26] keep their stored value on every write, whatever data is written there.
- R9: `caps_changed_o` is high for exactly the one cycle after an edge at which the stored value changed. It is low after any write that leaves the value as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| feat_en_i | input | 1 | Global write enable; low makes the register read-only |
| wr_strobe_i | input | 1 | Write request for this cycle |
| wr_data_i | input | 32 | Requested register value |
| fetch_aligned_i | input | 1 | High when the next fetch address is 4-byte aligned |
| isa_q_o | output | 32 | Current register value |
| caps_changed_o | output | 1 | One-cycle pulse after the stored value changes |

## Verification
The bench sends writes that carry E together with every other bit. A design that only masked E out, instead of dropping the write, would store the full legal set. Writes that lack I must leave the register untouched, and a D request without F must keep D cleared. The bench requests C once with the fetch misaligned and once with it aligned; a design that ignored alignment would keep C in the first case. It also writes ones into the base-width field and repeats identical writes: a design that copied the top bits would change the width field, and one that pulsed on every write, rather than on every change, would show a pulse where none is due.

// File: rtl/isa_cap_pkg.sv
package isa_cap_pkg;
  localparam int EXT_W = 26;
  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;

  function automatic logic [EXT_W-1:0] known_set();
    logic [EXT_W-1:0] s;
    s = '0;
    s[BIT_A] = 1'b1; s[BIT_C] = 1'b1; s[BIT_D] = 1'b1;
    s[BIT_E] = 1'b1; s[BIT_F] = 1'b1; s[BIT_I] = 1'b1;
    s[BIT_M] = 1'b1; s[BIT_S] = 1'b1; s[BIT_U] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/isa_write_filter.sv
module isa_write_filter
  import isa_cap_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [EXT_W-1:0] EXT_SUPPORT = 26'h014112D
) (
  input  logic [EXT_W-1:0]     req_ext_i,
  input  logic [XLEN-EXT_W-1:0] cur_top_i,
  input  logic                 fetch_aligned_i,
  output logic                 base_ok_o,
  output logic [XLEN-1:0]      legal_o
);
  localparam logic [EXT_W-1:0] ALLOWED = EXT_SUPPORT & known_set();

  logic [EXT_W-1:0] ext_masked;
  logic [EXT_W-1:0] ext_fixed;

  // whole-write drop: need I, and E is never accepted
  assign base_ok_o  = req_ext_i[BIT_I] && !req_ext_i[BIT_E];
  assign ext_masked = req_ext_i & ALLOWED;

  always_comb begin
    ext_fixed = ext_masked;
    if (ext_fixed[BIT_D] && !ext_fixed[BIT_F]) ext_fixed[BIT_D] = 1'b0;
    if (ext_fixed[BIT_C] && !fetch_aligned_i)  ext_fixed[BIT_C] = 1'b0;
  end

  assign legal_o = {cur_top_i, ext_fixed};

  always_comb begin
    if (base_ok_o) begin
      a_dfix_r6: assert (!(legal_o[BIT_D] && !legal_o[BIT_F]));
    end
  end
endmodule

// File: rtl/isa_cap_store.sv
module isa_cap_store #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] load_val_i,
  output logic [XLEN-1:0] q_o,
  output logic            changed_o
);
  logic [XLEN-1:0] q_d;
  logic            chg_d;
  logic            q_en;

  always_comb begin
    q_en  = load_i;
    q_d   = load_val_i;
    chg_d = load_i && (load_val_i != q_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o       <= RESET_VAL;
      changed_o <= 1'b0;
    end else begin
      if (q_en) q_o <= q_d;
      changed_o <= chg_d;
    end
  end
endmodule

// File: rtl/isa_cap_reg.sv
module isa_cap_reg
  import isa_cap_pkg::*;
#(
  parameter int               XLEN        = 32,
  parameter logic [1:0]       MXL_RESET   = 2'b01,
  parameter logic [EXT_W-1:0] EXT_SUPPORT = 26'h014112D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            feat_en_i,
  input  logic            wr_strobe_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            fetch_aligned_i,
  output logic [XLEN-1:0] isa_q_o,
  output logic            caps_changed_o
);
  localparam int              TOP_W     = XLEN - EXT_W;
  localparam logic [EXT_W-1:0] ALLOWED  = EXT_SUPPORT & known_set();
  localparam logic [XLEN-1:0] RESET_VAL = {MXL_RESET, {(TOP_W-2){1'b0}}, EXT_SUPPORT};

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic            base_ok;
  logic [XLEN-1:0] legal_val;
  logic            do_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  isa_write_filter #(.XLEN(XLEN), .EXT_SUPPORT(EXT_SUPPORT)) u_filter (
    .req_ext_i       (wr_data_i[EXT_W-1:0]),
    .cur_top_i       (isa_q_o[XLEN-1:EXT_W]),
    .fetch_aligned_i (fetch_aligned_i),
    .base_ok_o       (base_ok),
    .legal_o         (legal_val)
  );

  assign do_load = feat_en_i && wr_strobe_i && base_ok;

  isa_cap_store #(.XLEN(XLEN), .RESET_VAL(RESET_VAL)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (do_load),
    .load_val_i (legal_val),
    .q_o        (isa_q_o),
    .changed_o  (caps_changed_o)
  );

  p_feat_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !feat_en_i |=> $stable(isa_q_o));
  p_no_base_drop_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_strobe_i && !wr_data_i[BIT_I]) |=> $stable(isa_q_o));
  p_e_drop_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_strobe_i && wr_data_i[BIT_E]) |=> $stable(isa_q_o));
  p_subset_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(isa_q_o) |-> ((isa_q_o[EXT_W-1:0] & ~ALLOWED) == '0));
  p_c_align_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_strobe_i && !fetch_aligned_i) |=> (!isa_q_o[BIT_C] || $stable(isa_q_o)));
  p_top_keep_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_strobe_i && (wr_data_i[XLEN-1:EXT_W] != '0)) |=> $stable(isa_q_o[XLEN-1:EXT_W]));
  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(isa_q_o) |-> caps_changed_o);
  p_pulse_only_change_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    caps_changed_o |-> !$stable(isa_q_o));
endmodule

// File: tb/isa_cap_reg_tb_top.sv
module isa_cap_reg_tb_top;
  logic        clk;
  logic        rst_n;
  logic        feat_en;
  logic        wr_strobe;
  logic [31:0] wr_data;
  logic        aligned;
  logic [31:0] isa_q;
  logic        chg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [31:0] RST_Q = 32'h4014_112D;

  // {feat, strobe, aligned, data[31:0], exp_q[31:0], exp_pulse}
  localparam logic [67:0] VEC [14] = '{
    {3'b110, 32'h0000_0000, 32'h4014_112D, 1'b0},
    {3'b111, 32'h0000_0100, 32'h4000_0100, 1'b1},
    {3'b111, 32'h0000_0100, 32'h4000_0100, 1'b0},
    {3'b111, 32'hFFFF_FFFF, 32'h4000_0100, 1'b0},
    {3'b111, 32'h0000_1001, 32'h4000_0100, 1'b0},
    {3'b111, 32'h03FF_FFEF, 32'h4014_112D, 1'b1},
    {3'b111, 32'h0000_0108, 32'h4000_0100, 1'b1},
    {3'b111, 32'h0000_0128, 32'h4000_0128, 1'b1},
    {3'b110, 32'h0000_0104, 32'h4000_0100, 1'b1},
    {3'b111, 32'h0000_0104, 32'h4000_0104, 1'b1},
    {3'b011, 32'h0014_112D, 32'h4000_0104, 1'b0},
    {3'b111, 32'hC000_0100, 32'h4000_0100, 1'b1},
    {3'b111, 32'h0080_0100, 32'h4000_0100, 1'b0},
    {3'b110, 32'h0000_0100, 32'h4000_0100, 1'b0}
  };

  function automatic string req_of(int i);
    case (i)
      0, 2:    return "R9";
      1:       return "R5";
      3:       return "R4";
      4:       return "R3";
      5:       return "R8";
      6:       return "R6";
      7:       return "R6";
      8, 13:   return "R7";
      9:       return "R7";
      10:      return "R2";
      11:      return "R8";
      default: return "R5";
    endcase
  endfunction

  isa_cap_reg dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .feat_en_i       (feat_en),
    .wr_strobe_i     (wr_strobe),
    .wr_data_i       (wr_data),
    .fetch_aligned_i (aligned),
    .isa_q_o         (isa_q),
    .caps_changed_o  (chg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; feat_en = 1'b1; wr_strobe = 1'b0; wr_data = '0; aligned = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", isa_q, RST_Q);
    check("R1", {31'b0, chg}, 32'h0);

    for (int i = 0; i < 14; i++) begin
      {feat_en, wr_strobe, aligned, wr_data} = VEC[i][67:33];
      @(negedge clk);
      check(req_of(i), isa_q, VEC[i][32:1]);
      check("R9", {31'b0, chg}, {31'b0, VEC[i][0]});
    end
    wr_strobe = 1'b0;
    @(negedge clk);
    check("R9", {31'b0, chg}, 32'h0);

    // asynchronous reset mid-run restores the reset value at once
    #3 rst_n = 1'b0;
    #2 check("R1", isa_q, RST_Q);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", isa_q, RST_Q);

    // D with F but F unsupported path is covered; D alone after full set
    feat_en = 1'b1; wr_strobe = 1'b1; aligned = 1'b1; wr_data = 32'h0000_010C;
    @(negedge clk);
    check("R6", isa_q, 32'h4000_0104);
    check("R9", {31'b0, chg}, 32'h1);
    wr_strobe = 1'b0;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule